// File: doc/BRIEF.md
# Serial TDM Frame-Sync Tracker

This block locks both directions of a serial time-division-multiplexed port to a periodic frame-sync pulse. Each direction has its own tracker. A tracker counts bit clocks against a static frame length. It accepts a pulse as valid only when the pulse lands exactly on the expected frame boundary. It declares lock once enough valid pulses have been seen: two when the pulse-to-frame offset is zero, three when it is not. A missing pulse is bridged by the free-running position counter. Only a pulse seen at the wrong position breaks lock.

The trackers gate the data path. Receive bits are passed on a valid-only output stream, and only from slot 0 of the first frame that starts at or after lock. The transmit side raises a ready-style request from its own frame start onward. It drives the line and its output enable only while it is locked. The serial line cannot stall, so neither stream has back-pressure. The receive consumer must take every bit that is flagged valid. On the transmit side, a cycle in which the request is high but the source offers no valid bit sends a fill value of 1, and lock is not affected. A loopback mode feeds the transmit frame-sync and the transmit line into the receive tracker and receive data path, so the receive pins are not used.

Frame length and offset are static configuration inputs. Changing either, or asserting reset, returns both trackers to the unlocked state with no pulses counted.

Top module: `tdm_sync_tracker`

## Requirements
- R1: With offset 0, a tracker is unlocked after the first pulse and locked right after the edge that samples the second pulse, provided that pulse arrives exactly frame-length cycles after the first.
- R2: With a non-zero offset, lock needs three pulses, each spaced frame-length cycles from the one before. The tracker is still unlocked after the second.
- R3: rx_valid is low whenever receive is unlocked. The first bit delivered after lock is frame slot 0, which is position (frame_len - offset) mod frame_len, where position 0 is the pulse cycle. With offset 0 this is the locking pulse cycle itself. rx_slot0 is high with every slot-0 bit.
- R4: While rx_valid is high, rx_bit is the receive input that was sampled at the same clock edge.
- R5: A missing frame pulse keeps lock, and rx_slot0 still appears at the boundary where the pulse was expected.
- R6: A pulse at any position other than the expected boundary clears lock and rx_valid at once. It also counts as the first pulse of a new acquisition, so with offset 0 one more on-time pulse locks again.
- R7: The transmit tracker uses the same rule on tx_fsync. tx_req stays low until tx is locked. It then rises at transmit slot 0, which is offset cycles before the next pulse, or the locking pulse cycle when offset is 0.
- R8: tx_oe is high exactly while the transmit side is locked. A bit is accepted when tx_req and tx_valid are both high, and it appears on tx_sdo one cycle later. A cycle with tx_req high and tx_valid low sends 1, and lock is kept.
- R9: With loopback high, the receive tracker follows tx_fsync and receive data comes from tx_sdo. rx_fsync and rx_sdi have no effect.
- R10: Reset, or any change of cfg_frame_len or cfg_offset, returns both trackers to unlocked on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_frame_len | input | LEN_W | Frame length in bit clocks, at least 2 |
| cfg_offset | input | LEN_W | Pulse-to-frame offset, less than frame length |
| loopback | input | 1 | Routes the transmit sync and the transmit line to the receive side |
| rx_fsync | input | 1 | Receive frame-sync pulse |
| rx_sdi | input | 1 | Receive serial data |
| tx_fsync | input | 1 | Transmit frame-sync pulse |
| tx_valid | input | 1 | Transmit source has a bit |
| tx_bit | input | 1 | Transmit data bit |
| rx_locked | output | 1 | Receive tracker locked |
| rx_valid | output | 1 | rx_bit carries a frame bit |
| rx_bit | output | 1 | Received data bit |
| rx_slot0 | output | 1 | Delivered bit is slot 0 of a frame |
| tx_locked | output | 1 | Transmit tracker locked |
| tx_req | output | 1 | Ready for a transmit bit |
| tx_oe | output | 1 | Transmit output enable; pin is high impedance when low |
| tx_sdo | output | 1 | Transmit serial data |

## Verification
Lock acquisition is run with evenly spaced pulses over four pairs of frame length and offset, zero and non-zero. These runs separate the two-pulse rule from the three-pulse rule and pin down where slot 0 falls, including an offset only one cycle short of the frame. Directed patterns then drop a pulse from a locked stream, which must be bridged, and insert one early, which must break lock and restart the count. These two cases show that the tracker keys on position and not on pulse count. Transmit runs cover request timing with and without an offset, as well as fill bits on underrun. Loopback is run with the receive pins held against the expected data. A mid-run configuration change and a reset show that all state is cleared.

// File: rtl/tdm_sync_pkg.sv
package tdm_sync_pkg;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_ONE  = 2'd1,
    ACQ_TWO  = 2'd2,
    ACQ_LOCK = 2'd3
  } acq_state_e;

  // One more qualifying pulse is needed when the frame start is offset.
  function automatic acq_state_e after_on_time(input acq_state_e cur, input logic has_offset);
    case (cur)
      ACQ_ONE: after_on_time = has_offset ? ACQ_TWO : ACQ_LOCK;
      ACQ_TWO: after_on_time = ACQ_LOCK;
      ACQ_LOCK: after_on_time = ACQ_LOCK;
      default: after_on_time = ACQ_ONE;
    endcase
  endfunction

endpackage

// File: rtl/tdm_sync_track.sv
module tdm_sync_track #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             fsync,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             has_offset,
  output logic [LEN_W-1:0] pos_now,
  output logic             lock_now
);
  import tdm_sync_pkg::*;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] pos_q;
  acq_state_e       st_q, st_d;
  logic             at_end, on_time;

  assign at_end  = (pos_q == frame_len - ONE);
  assign on_time = (st_q != ACQ_IDLE) && at_end;

  // Position of the current cycle; the flywheel wraps so a gapped pulse is bridged.
  always_comb begin
    if (fsync || at_end) pos_now = '0;
    else                 pos_now = pos_q + ONE;
  end

  always_comb begin
    st_d = st_q;
    if (fsync) begin
      if (on_time) st_d = after_on_time(st_q, has_offset);
      else         st_d = ACQ_ONE;  // misplaced pulse becomes a new first pulse
    end
  end

  assign lock_now = !clear && (st_d == ACQ_LOCK);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos_q <= '0;
      st_q  <= ACQ_IDLE;
    end else begin
      pos_q <= pos_now;
      st_q  <= st_d;
    end
  end
endmodule

// File: rtl/tdm_frame_gate.sv
module tdm_frame_gate #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_now,
  input  logic [LEN_W-1:0] pos_now,
  input  logic [LEN_W-1:0] start_pos,
  output logic             open_now,
  output logic             start_hit
);
  logic open_q;
  logic at_start;

  assign at_start  = (pos_now == start_pos);
  assign open_now  = lock_now && (open_q || at_start);
  assign start_hit = open_now && at_start;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_now;
  end
endmodule

// File: rtl/tdm_sync_tracker.sv
module tdm_sync_tracker #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_frame_len,
  input  logic [LEN_W-1:0] cfg_offset,
  input  logic             loopback,
  input  logic             rx_fsync,
  input  logic             rx_sdi,
  input  logic             tx_fsync,
  input  logic             tx_valid,
  input  logic             tx_bit,
  output logic             rx_locked,
  output logic             rx_valid,
  output logic             rx_bit,
  output logic             rx_slot0,
  output logic             tx_locked,
  output logic             tx_req,
  output logic             tx_oe,
  output logic             tx_sdo
);
  localparam int DIRS  = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  logic [LEN_W-1:0] len_q, off_q;
  logic             cfg_dirty;
  logic             has_offset;
  logic [LEN_W-1:0] start_pos;
  logic             rx_src;

  logic [DIRS-1:0]  fs_in;
  logic [DIRS-1:0]  lock_now;
  logic [DIRS-1:0]  open_now;
  logic [DIRS-1:0]  start_hit;
  logic [LEN_W-1:0] pos_now [DIRS];

  assign cfg_dirty  = (cfg_frame_len != len_q) || (cfg_offset != off_q);
  assign has_offset = (cfg_offset != '0);
  assign start_pos  = has_offset ? (cfg_frame_len - cfg_offset) : '0;

  assign fs_in[DIR_RX] = loopback ? tx_fsync : rx_fsync;
  assign fs_in[DIR_TX] = tx_fsync;
  assign rx_src        = loopback ? tx_sdo : rx_sdi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      off_q <= '0;
    end else begin
      len_q <= cfg_frame_len;
      off_q <= cfg_offset;
    end
  end

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    tdm_sync_track #(.LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (cfg_dirty),
      .fsync      (fs_in[d]),
      .frame_len  (cfg_frame_len),
      .has_offset (has_offset),
      .pos_now    (pos_now[d]),
      .lock_now   (lock_now[d])
    );

    tdm_frame_gate #(.LEN_W(LEN_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_now  (lock_now[d]),
      .pos_now   (pos_now[d]),
      .start_pos (start_pos),
      .open_now  (open_now[d]),
      .start_hit (start_hit[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_locked <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      rx_slot0  <= 1'b0;
    end else begin
      rx_locked <= lock_now[DIR_RX];
      rx_valid  <= open_now[DIR_RX];
      rx_bit    <= open_now[DIR_RX] ? rx_src : 1'b0;
      rx_slot0  <= start_hit[DIR_RX];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_locked <= 1'b0;
      tx_oe     <= 1'b0;
      tx_req    <= 1'b0;
      tx_sdo    <= 1'b1;
    end else begin
      tx_locked <= lock_now[DIR_TX];
      tx_oe     <= lock_now[DIR_TX];
      tx_req    <= open_now[DIR_TX];
      tx_sdo    <= (tx_req && tx_valid) ? tx_bit : 1'b1;
    end
  end
endmodule

// File: rtl/tdm_sync_tracker_chk.sv
module tdm_sync_tracker_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LEN_W-1:0] cfg_frame_len,
  input logic [LEN_W-1:0] cfg_offset,
  input logic             loopback,
  input logic             rx_fsync,
  input logic             tx_fsync,
  input logic             rx_locked,
  input logic             rx_valid,
  input logic             rx_slot0,
  input logic             tx_locked,
  input logic             tx_req,
  input logic             tx_oe
);
  assert_valid_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_locked);

  assert_first_bit_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> rx_slot0);

  assert_lock_on_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_locked) |-> $past(loopback ? tx_fsync : rx_fsync));

  assert_req_needs_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_oe && tx_locked));

  assert_cfg_change_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_frame_len) || !$stable(cfg_offset)) |=> (!rx_locked && !tx_locked));
endmodule

bind tdm_sync_tracker tdm_sync_tracker_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_frame_len (cfg_frame_len),
  .cfg_offset    (cfg_offset),
  .loopback      (loopback),
  .rx_fsync      (rx_fsync),
  .tx_fsync      (tx_fsync),
  .rx_locked     (rx_locked),
  .rx_valid      (rx_valid),
  .rx_slot0      (rx_slot0),
  .tx_locked     (tx_locked),
  .tx_req        (tx_req),
  .tx_oe         (tx_oe)
);

// File: tb/tdm_sync_tracker_tb.sv
`timescale 1ns/1ps
module tdm_sync_tracker_tb;
  localparam int LEN_W = 8;
  localparam int NVEC  = 4;
  // frame length, offset, pulses needed
  localparam int VEC [NVEC][3] = '{'{8, 0, 2}, '{8, 3, 3}, '{5, 0, 2}, '{12, 11, 3}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LEN_W-1:0] cfg_frame_len = 8'd8;
  logic [LEN_W-1:0] cfg_offset = 8'd0;
  logic loopback = 1'b0;
  logic rx_fsync = 1'b0, rx_sdi = 1'b0, tx_fsync = 1'b0, tx_valid = 1'b0, tx_bit = 1'b1;
  logic rx_locked, rx_valid, rx_bit, rx_slot0, tx_locked, tx_req, tx_oe, tx_sdo;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tdm_sync_tracker #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_frame_len(cfg_frame_len), .cfg_offset(cfg_offset),
    .loopback(loopback), .rx_fsync(rx_fsync), .rx_sdi(rx_sdi), .tx_fsync(tx_fsync),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .rx_locked(rx_locked), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_slot0(rx_slot0), .tx_locked(tx_locked), .tx_req(tx_req),
    .tx_oe(tx_oe), .tx_sdo(tx_sdo)
  );

  task automatic tick(input logic rf, input logic tf);
    @(negedge clk);
    rx_fsync = rf;
    tx_fsync = tf;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0);
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state (R10)
    idle(3);
    chk(rx_locked, 1'b0, "R10", "rx_locked in reset");
    chk(tx_oe, 1'b0, "R10", "tx_oe in reset");
    chk(rx_valid, 1'b0, "R10", "rx_valid in reset");
    chk(tx_req, 1'b0, "R10", "tx_req in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: acquisition and slot-0 placement (R1 R2 R3 R4)
    for (int e = 0; e < NVEC; e++) begin
      int len, off, need;
      len = VEC[e][0];
      off = VEC[e][1];
      need = VEC[e][2];
      cfg_frame_len = LEN_W'(len);
      cfg_offset = LEN_W'(off);
      idle(2);
      for (int k = 1; k <= need; k++) begin
        tick(1'b1, 1'b0);
        chk(rx_locked, k == need, (need == 2) ? "R1" : "R2", "rx_locked after pulse");
        chk(rx_valid, (k == need) && (off == 0), "R3", "rx_valid at pulse");
        if (k < need) begin
          idle(len - 1);
          chk(rx_valid, 1'b0, "R3", "rx_valid before lock");
        end
      end
      for (int j = 1; j < len; j++) begin
        logic ev;
        rx_sdi = j[0];
        tick(1'b0, 1'b0);
        ev = (off == 0) || (j >= len - off);
        chk(rx_valid, ev, "R3", "rx_valid after lock");
        chk(rx_slot0, (off != 0) && (j == len - off), "R3", "rx_slot0 position");
        if (ev) chk(rx_bit, j[0], "R4", "rx_bit data");
      end
      tick(1'b1, 1'b0);
      chk(rx_locked, 1'b1, "R5", "lock held on next pulse");
    end

    // config change clears lock (R10)
    cfg_frame_len = 8'd8;
    cfg_offset = 8'd0;
    tick(1'b0, 1'b0);
    chk(rx_locked, 1'b0, "R10", "rx_locked after cfg change");

    // gapped pulse (R5)
    tick(1'b1, 1'b0);
    idle(7);
    tick(1'b1, 1'b0);
    chk(rx_locked, 1'b1, "R1", "relock len 8");
    idle(7);
    tick(1'b0, 1'b0);
    chk(rx_locked, 1'b1, "R5", "lock across missing pulse");
    chk(rx_slot0, 1'b1, "R5", "slot0 at missing pulse");
    idle(7);
    tick(1'b1, 1'b0);
    chk(rx_locked, 1'b1, "R5", "lock after gap");

    // misplaced pulse (R6)
    idle(4);
    tick(1'b1, 1'b0);
    chk(rx_locked, 1'b0, "R6", "rx_locked after misplaced pulse");
    chk(rx_valid, 1'b0, "R6", "rx_valid after misplaced pulse");
    idle(7);
    tick(1'b1, 1'b0);
    chk(rx_locked, 1'b1, "R6", "relock counting misplaced pulse");

    // transmit lock, request, enable, data and underrun (R7 R8)
    tick(1'b0, 1'b1);
    chk(tx_oe, 1'b0, "R8", "tx_oe before lock");
    chk(tx_req, 1'b0, "R7", "tx_req before lock");
    idle(7);
    tick(1'b0, 1'b1);
    chk(tx_locked, 1'b1, "R7", "tx_locked after second pulse");
    chk(tx_oe, 1'b1, "R8", "tx_oe when locked");
    chk(tx_req, 1'b1, "R7", "tx_req at frame start");
    tx_valid = 1'b1;
    tx_bit = 1'b0;
    tick(1'b0, 1'b0);
    chk(tx_sdo, 1'b0, "R8", "tx_sdo carries accepted bit");
    tx_valid = 1'b0;
    tick(1'b0, 1'b0);
    chk(tx_sdo, 1'b1, "R8", "tx_sdo fill on underrun");
    chk(tx_locked, 1'b1, "R8", "tx lock kept on underrun");

    // transmit with offset (R7)
    cfg_offset = 8'd3;
    idle(2);
    for (int k = 1; k <= 3; k++) begin
      tick(1'b0, 1'b1);
      if (k < 3) idle(7);
    end
    chk(tx_req, 1'b0, "R7", "tx_req at locking pulse with offset");
    for (int j = 1; j < 8; j++) begin
      tick(1'b0, 1'b0);
      chk(tx_req, j >= 5, "R7", "tx_req offset timing");
    end

    // loopback (R9)
    cfg_offset = 8'd0;
    loopback = 1'b1;
    idle(2);
    tick(1'b0, 1'b1);
    idle(7);
    tick(1'b0, 1'b1);
    chk(rx_locked, 1'b1, "R9", "rx locks on tx sync in loopback");
    tx_valid = 1'b1;
    tx_bit = 1'b0;
    rx_sdi = 1'b1;
    tick(1'b0, 1'b0);
    tx_valid = 1'b0;
    tick(1'b0, 1'b0);
    chk(rx_valid, 1'b1, "R9", "rx_valid in loopback");
    chk(rx_bit, 1'b0, "R9", "rx_bit from tx line");

    // reset while locked (R10)
    @(negedge clk);
    rst_n = 1'b0;
    tick(1'b0, 1'b0);
    chk(rx_locked, 1'b0, "R10", "rx_locked after reset");
    chk(tx_oe, 1'b0, "R10", "tx_oe after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule